// File: doc/BRIEF.md
# DMA Descriptor Auto-Poll Timer

This block tells the transmit and receive DMA engines of a 10/100 MAC when to go and fetch their next descriptor. Each direction gets a fetch request from one of two sources: a software poll-demand write, which asks for a fetch at once, or a periodic timer. The timer period is a 4-bit count of cycle units. A count of zero turns periodic polling off for that direction.

The cycle unit has two lengths, normal and long, and the clock count behind each length depends on link speed. With the default parameters and a 125 MHz clock the units are 5.12 us and 81.92 us at 100 Mb/s, and 51.2 us and 819.2 us at 10 Mb/s. Each DMA engine sees a one-clock fetch strobe.

A request that cannot be served at once is held pending. It is held while the DMA engine of that direction is disabled, or while an earlier strobe is still going out. Further requests that arrive in that time are merged into the one that is pending. Ring walking, ownership checks and bus mastering are done elsewhere.

Top module: `dma_poll_timer`

## Requirements
- R1: A write with `wr_sel` = 0 loads the poll-control fields from `wr_data`. The transmit count is bits 11:8 and the transmit long-unit select is bit 12. The receive count is bits 3:0 and the receive long-unit select is bit 4. All other bits are ignored.
- R2: After reset the transmit count is 0 and the receive count is 1, with the normal unit selected for both directions.
- R3: With a nonzero count C and a unit of U clocks, a direction strobes every C*U clocks. The first strobe follows the clock edge C*U edges after the last restart. A restart is any of: the first edge after reset release, a control write, or a poll-demand write for that direction.
- R4: The unit is `NORM_FAST` or `LONG_FAST` clocks when `speed_100` is 1, and `NORM_SLOW` or `LONG_SLOW` clocks when it is 0. The long-unit select bit picks the long value.
- R5: A count of 0 produces no periodic strobes in that direction.
- R6: A write with `wr_sel` = 1 (transmit) or `wr_sel` = 2 (receive), whatever the data, makes that direction strobe in the cycle after the write edge.
- R7: A poll-demand write restarts the periodic timer of its own direction only.
- R8: While a direction's DMA enable is low, its strobe stays low. The pending request is kept, and its strobe appears in the first cycle the enable is high.
- R9: Each strobe lasts exactly one clock. A request that arrives while one is pending is merged into it, including a request in the strobe cycle itself and a demand in the same cycle as a timer expiry.
- R10: A write with `wr_sel` = 3 has no effect: it causes no strobe and no timer restart.
- R11: The two directions run independently: a demand or a strobe in one does not cause a strobe in the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_100 | input | 1 | 1 = 100 Mb/s link, 0 = 10 Mb/s |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 control, 1 transmit demand, 2 receive demand, 3 none |
| wr_data | input | DATA_W | Write data |
| tx_dma_en | input | 1 | Transmit DMA enable |
| rx_dma_en | input | 1 | Receive DMA enable |
| tx_fetch | output | 1 | Transmit descriptor fetch strobe |
| rx_fetch | output | 1 | Receive descriptor fetch strobe |

## Verification
A poll-demand write and a timer expiry can fall in the same cycle, and so can a demand and the strobe of an earlier request. The bench forces both cases. It times a transmit demand to land on the exact edge where the periodic count expires, and it issues a second demand on the edge where the first strobe is showing. It then expects one strobe only, a low output in the following cycle, and the next periodic strobe one full period after the demand.

// File: rtl/dma_poll_timer.sv
module dma_poll_timer #(
  parameter int NORM_FAST = 640,
  parameter int LONG_FAST = 10240,
  parameter int NORM_SLOW = 6400,
  parameter int LONG_SLOW = 102400,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              speed_100,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tx_dma_en,
  input  logic              rx_dma_en,
  output logic              tx_fetch,
  output logic              rx_fetch
);
  localparam int CNT_W = 4;
  localparam int MAX_F = (NORM_FAST > LONG_FAST) ? NORM_FAST : LONG_FAST;
  localparam int MAX_S = (NORM_SLOW > LONG_SLOW) ? NORM_SLOW : LONG_SLOW;
  localparam int MAX_U = (MAX_F > MAX_S) ? MAX_F : MAX_S;
  localparam int PRE_W = $clog2(MAX_U + 1);
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_TXPD = 2'd1;
  localparam logic [1:0] SEL_RXPD = 2'd2;

  logic [1:0][CNT_W-1:0] cnt;
  logic [1:0]            lng;
  logic [1:0]            dem;
  logic [1:0]            en;
  logic [1:0]            fire;
  logic                  cfg_wr;

  assign cfg_wr = wr_en && (wr_sel == SEL_CTRL);
  assign dem    = {wr_en && (wr_sel == SEL_RXPD), wr_en && (wr_sel == SEL_TXPD)};
  assign en     = {rx_dma_en, tx_dma_en};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= {CNT_W'(1), CNT_W'(0)};
      lng <= 2'b00;
    end else if (cfg_wr) begin
      cnt[0] <= wr_data[11:8];
      lng[0] <= wr_data[12];
      cnt[1] <= wr_data[3:0];
      lng[1] <= wr_data[4];
    end
  end

  for (genvar d = 0; d < 2; d++) begin : g_dir
    logic [PRE_W-1:0] pre;
    logic [PRE_W-1:0] ulen;
    logic [CNT_W-1:0] ucnt;
    logic             pend;
    logic             restart;
    logic             tick;
    logic             expire;

    assign ulen = lng[d] ? (speed_100 ? PRE_W'(LONG_FAST) : PRE_W'(LONG_SLOW))
                         : (speed_100 ? PRE_W'(NORM_FAST) : PRE_W'(NORM_SLOW));
    assign restart = dem[d] || cfg_wr || (cnt[d] == '0);
    assign tick    = (pre >= ulen - PRE_W'(1));
    assign expire  = !restart && tick && (ucnt >= cnt[d] - CNT_W'(1));
    assign fire[d] = pend && en[d];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pre  <= '0;
        ucnt <= '0;
        pend <= 1'b0;
      end else begin
        if (restart) begin
          pre  <= '0;
          ucnt <= '0;
        end else if (tick) begin
          pre  <= '0;
          ucnt <= expire ? '0 : ucnt + CNT_W'(1);
        end else begin
          pre  <= pre + PRE_W'(1);
        end
        pend <= pend ? !fire[d] : (dem[d] || expire);
      end
    end
  end

  assign tx_fetch = fire[0];
  assign rx_fetch = fire[1];
endmodule

// File: rtl/dma_poll_timer_chk.sv
module dma_poll_timer_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              speed_100,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic              tx_dma_en,
  input logic              rx_dma_en,
  input logic              tx_fetch,
  input logic              rx_fetch
);
  AST_TX_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n) tx_fetch |=> !tx_fetch); // R9
  AST_RX_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n) rx_fetch |=> !rx_fetch); // R9
  AST_TX_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !tx_dma_en |-> !tx_fetch); // R8
  AST_RX_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !rx_dma_en |-> !rx_fetch); // R8
  AST_TX_DEMAND: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd1 && tx_dma_en && !tx_fetch) |=> (tx_fetch || !tx_dma_en)); // R6
  AST_RX_DEMAND: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd2 && rx_dma_en && !rx_fetch) |=> (rx_fetch || !rx_dma_en)); // R6
endmodule

bind dma_poll_timer dma_poll_timer_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/dma_poll_timer_bench.sv
`timescale 1ns/1ps
module dma_poll_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        speed_100 = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd3;
  logic [31:0] wr_data = '0;
  logic        tx_dma_en = 1'b1;
  logic        rx_dma_en = 1'b1;
  logic        tx_fetch, rx_fetch;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dma_poll_timer #(.NORM_FAST(4), .LONG_FAST(16), .NORM_SLOW(10), .LONG_SLOW(40)) u_dma_poll_timer (
    .clk(clk), .rst_n(rst_n), .speed_100(speed_100), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .tx_dma_en(tx_dma_en), .rx_dma_en(rx_dma_en),
    .tx_fetch(tx_fetch), .rx_fetch(rx_fetch));

  localparam int NV = 6;
  localparam logic [31:0] CTRL_V [NV] = '{32'h0000_0203, 32'h0000_1100, 32'h0000_0012,
                                          32'h0000_0301, 32'hFFFF_E0E0, 32'h0000_0F1F};
  localparam bit SPD_V [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
  localparam int EXP_TX [NV] = '{8, 16, 0, 30, 0, 60};
  localparam int EXP_RX [NV] = '{12, 0, 80, 10, 0, 240};

  task automatic check(input int act, input int exp, input string req);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    wr_en = 1'b1;
    wr_sel = sel;
    wr_data = data;
    step();
    wr_en = 1'b0;
    wr_sel = 2'd3;
  endtask

  task automatic run_entry(input int i);
    int w, tf, ts, th, rf, rs, rh, m;
    m = (EXP_TX[i] > EXP_RX[i]) ? EXP_TX[i] : EXP_RX[i];
    w = (m == 0) ? 50 : 2 * m + 4;
    tf = 0; ts = 0; th = 0; rf = 0; rs = 0; rh = 0;
    speed_100 = SPD_V[i];
    wr(2'd0, CTRL_V[i]);
    for (int j = 1; j <= w; j++) begin
      step();
      if (tx_fetch) begin th++; if (th == 1) tf = j; else if (th == 2) ts = j; end
      if (rx_fetch) begin rh++; if (rh == 1) rf = j; else if (rh == 2) rs = j; end
    end
    if (EXP_TX[i] > 0) begin
      check(tf, EXP_TX[i], $sformatf("R3 R4 R1 tx first, entry %0d", i));
      check(ts - tf, EXP_TX[i], $sformatf("R3 tx period, entry %0d", i));
    end else check(th, 0, $sformatf("R5 tx none, entry %0d", i));
    if (EXP_RX[i] > 0) begin
      check(rf, EXP_RX[i], $sformatf("R3 R4 R1 rx first, entry %0d", i));
      check(rs - rf, EXP_RX[i], $sformatf("R3 rx period, entry %0d", i));
    end else check(rh, 0, $sformatf("R5 rx none, entry %0d", i));
  endtask

  initial begin
    int tf, rf, th, rh;
    repeat (3) step();
    check(tx_fetch, 0, "R2 reset tx quiet");
    check(rx_fetch, 0, "R2 reset rx quiet");
    rst_n = 1'b1;
    tf = 0; rf = 0; th = 0; rh = 0;
    for (int j = 1; j <= 10; j++) begin
      step();
      if (tx_fetch) th++;
      if (rx_fetch) begin rh++; if (rh == 1) rf = j; end
    end
    check(rf, 4, "R2 default rx one normal unit");
    check(rh, 2, "R2 default rx strobe count");
    check(th, 0, "R2 default tx off");

    for (int i = 0; i < NV; i++) run_entry(i);

    speed_100 = 1'b1;
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h0);
    check(tx_fetch, 1, "R6 tx demand strobe");
    check(rx_fetch, 0, "R11 rx untouched by tx demand");
    step();
    check(tx_fetch, 0, "R9 tx strobe one clock");
    wr(2'd2, 32'hDEAD_BEEF);
    check(rx_fetch, 1, "R6 rx demand strobe");
    check(tx_fetch, 0, "R11 tx untouched by rx demand");
    wr(2'd1, 32'h0);
    check(tx_fetch, 1, "R6 tx demand again");
    wr(2'd1, 32'h0);
    check(tx_fetch, 0, "R9 demand in strobe cycle merged");
    step();
    check(tx_fetch, 0, "R9 no late strobe");

    wr(2'd0, 32'h0000_0202);
    repeat (4) step();
    wr(2'd1, 32'h0);
    check(tx_fetch, 1, "R7 demand strobe");
    repeat (3) step();
    check(rx_fetch, 1, "R7 rx keeps own period");
    check(tx_fetch, 0, "R7 tx timer restarted");
    repeat (5) step();
    check(tx_fetch, 1, "R7 tx period from demand");

    wr(2'd0, 32'h0000_0200);
    repeat (7) step();
    wr(2'd1, 32'h0);
    check(tx_fetch, 1, "R9 demand with expiry strobes");
    step();
    check(tx_fetch, 0, "R9 demand with expiry merged");
    repeat (7) step();
    check(tx_fetch, 1, "R9 next period after merge");

    wr(2'd0, 32'h0);
    tx_dma_en = 1'b0;
    wr(2'd1, 32'h0);
    check(tx_fetch, 0, "R8 held while disabled");
    repeat (3) step();
    wr(2'd1, 32'h0);
    check(tx_fetch, 0, "R8 still held");
    tx_dma_en = 1'b1;
    #1;
    check(tx_fetch, 1, "R8 strobe when enabled");
    step();
    check(tx_fetch, 0, "R9 merged demands one strobe");

    wr(2'd0, 32'h0000_0002);
    repeat (3) step();
    wr(2'd3, 32'hFFFF_FFFF);
    check(tx_fetch, 0, "R10 sel3 no tx strobe");
    check(rx_fetch, 0, "R10 sel3 no rx strobe");
    repeat (4) step();
    check(rx_fetch, 1, "R10 sel3 no restart");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule